// File: doc/BRIEF.md
# ADC Auto-Trigger Source Selector

This block decides when an analog-to-digital converter begins a conversion on its own. A small control register holds a 3-bit source code. The code picks one of eight signals: the converter's own conversion-complete flag, or one of seven peripheral event flags. The block watches the picked signal and sends a start pulse, one clock wide, to the converter when that signal goes from low to high.

The rising edge is detected after the multiplexer, not separately on each source. A change of selection can therefore create an edge by itself: moving from a low source to a high one counts as a rise. The one exception is free-running mode (code 000). Moving into that mode never fires, even when conversion-complete is already high. After that, each new rise of conversion-complete starts the next conversion, so the converter runs back to back.

A trigger is passed on only when auto-triggering and the converter are both enabled and the converter is idle. A trigger that meets a busy converter is lost; it is not held for later. All pins are plain control and status levels: the block moves no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `adc_trig_sel`

## Requirements
- R1: The source code in bits [2:0] of the control register selects the trigger signal. 000 selects `conv_done` (free-running). 001 to 111 select `evt_flags[0]` to `evt_flags[6]`, in this order: analog comparator, external interrupt 0, timer 0 compare match, timer 0 overflow, timer compare match B, timer 1 overflow, timer 1 capture.
- R2: While `auto_en` is low, no source and no change of selection causes `start_pulse`.
- R3: A trigger comes from a low-to-high change of the selected signal, never from its level. A signal that stays high gives exactly one pulse. The pulse appears on the clock edge after the first clock edge at which the signal is sampled high.
- R4: Writing a new code that moves from a source sampled low to a source that is high counts as a rising edge and fires a start.
- R5: While `adc_en` is low, no start is issued.
- R6: A write that changes the code from a nonzero value to 000 never fires on that change, even when `conv_done` is already high.
- R7: Only bits [2:0] of `cfg_wr_data` are stored. `cfg_rd_data` returns the stored code in bits [2:0]. Bits [7:3], including reserved bit 7, always read as zero, and writing ones to them has no effect.
- R8: The delayed copy of the selected signal keeps tracking while `auto_en` is low. Raising `auto_en` while the selected signal is already high therefore does not fire.
- R9: In free-running mode, each rising edge of `conv_done` fires a start.
- R10: An edge that arrives while `conv_busy` is high is dropped. It does not fire later, after `conv_busy` falls.
- R11: `start_pulse` is never high on two clock edges in a row. Reset sets the code to 000, with `start_pulse` low and no pending edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Write strobe for the control register |
| cfg_wr_data | input | 8 | Write data for the control register |
| cfg_rd_data | output | 8 | Read-back of the control register |
| auto_en | input | 1 | Auto-trigger enable |
| adc_en | input | 1 | Converter enable |
| evt_flags | input | 7 | Peripheral event flags for codes 001 to 111 |
| conv_done | input | 1 | Converter conversion-complete flag (source for code 000) |
| conv_busy | input | 1 | Converter is busy with a conversion |
| start_pulse | output | 1 | One-clock start-of-conversion request |

## Verification
The hardest situations to reach are the ones where an edge is created by a register write rather than by a flag moving. Two of them matter most: a switch from a low source to a high one, and a switch into free-running mode while `conv_done` is already high. Here the stimulus first holds the flags steady for several cycles, so the delayed copy settles. Only then does it write the new code, with no flag changing in that cycle. In the same way, the no-false-edge case on enabling is reached by raising the selected flag while `auto_en` is low and turning `auto_en` on some cycles later.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  localparam int NUM_SRC = 8;
  localparam int SEL_W   = $clog2(NUM_SRC);
  localparam int REG_W   = 8;
  typedef logic [SEL_W-1:0] trig_sel_t;
  localparam trig_sel_t SEL_FREE_RUN = '0;
endpackage

// File: rtl/adc_trig_cfg_reg.sv
module adc_trig_cfg_reg #(
  parameter int REG_W = adc_trig_pkg::REG_W,
  parameter int SEL_W = adc_trig_pkg::SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic [SEL_W-1:0] sel
);
  localparam int PAD_W = REG_W - SEL_W;

  logic [SEL_W-1:0] sel_r;

  // Only the source code is stored; upper bits, reserved included, are dropped.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sel_r <= '0;
    else if (wr_en) sel_r <= wr_data[SEL_W-1:0];
  end

  assign sel     = sel_r;
  assign rd_data = {{PAD_W{1'b0}}, sel_r};
endmodule

// File: rtl/adc_trig_src_mux.sv
module adc_trig_src_mux #(
  parameter int NUM_SRC = adc_trig_pkg::NUM_SRC,
  parameter int SEL_W   = adc_trig_pkg::SEL_W
) (
  input  logic [SEL_W-1:0]   sel,
  input  logic               conv_done,
  input  logic [NUM_SRC-2:0] evt_flags,
  output logic               muxed
);
  logic [NUM_SRC-1:0] src_vec;

  // Slot zero is the converter's own completion flag (free-running).
  assign src_vec[0] = conv_done;
  for (genvar i = 1; i < NUM_SRC; i++) begin : g_src
    assign src_vec[i] = evt_flags[i-1];
  end

  assign muxed = src_vec[sel];
endmodule

// File: rtl/adc_trig_edge_gen.sv
module adc_trig_edge_gen #(
  parameter int SEL_W = adc_trig_pkg::SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             muxed,
  input  logic             auto_en,
  input  logic             adc_en,
  input  logic             conv_busy,
  output logic             start_pulse
);
  logic             sig_q;
  logic [SEL_W-1:0] sel_q;
  logic             start_q;
  logic             rise;
  logic             enter_fr;
  logic             fire;

  assign rise     = muxed & ~sig_q;
  assign enter_fr = (sel == '0) & (sel_q != '0);
  assign fire     = rise & ~enter_fr & auto_en & adc_en & ~conv_busy;

  // sig_q tracks regardless of enables so enabling never forges an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q   <= 1'b0;
      sel_q   <= '0;
      start_q <= 1'b0;
    end else begin
      sig_q   <= muxed;
      sel_q   <= sel;
      start_q <= fire;
    end
  end

  assign start_pulse = start_q;
endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
  import adc_trig_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr_en,
  input  logic [REG_W-1:0]   cfg_wr_data,
  output logic [REG_W-1:0]   cfg_rd_data,
  input  logic               auto_en,
  input  logic               adc_en,
  input  logic [NUM_SRC-2:0] evt_flags,
  input  logic               conv_done,
  input  logic               conv_busy,
  output logic               start_pulse
);
  trig_sel_t sel;
  logic      muxed;

  adc_trig_cfg_reg #(.REG_W(REG_W), .SEL_W(SEL_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .rd_data(cfg_rd_data), .sel(sel)
  );

  adc_trig_src_mux #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_mux (
    .sel(sel), .conv_done(conv_done), .evt_flags(evt_flags), .muxed(muxed)
  );

  adc_trig_edge_gen #(.SEL_W(SEL_W)) u_edge (
    .clk(clk), .rst_n(rst_n), .sel(sel), .muxed(muxed), .auto_en(auto_en),
    .adc_en(adc_en), .conv_busy(conv_busy), .start_pulse(start_pulse)
  );
endmodule

// File: rtl/adc_trig_sel_chk.sv
module adc_trig_sel_chk
  import adc_trig_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [REG_W-1:0] cfg_rd_data,
  input logic             auto_en,
  input logic             adc_en,
  input logic             conv_busy,
  input logic             start_pulse
);
  // R11
  one_cycle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);

  // R2
  auto_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |=> !start_pulse);

  // R5
  adc_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_en |=> !start_pulse);

  // R10
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_busy |=> !start_pulse);

  // R7
  upper_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_data[REG_W-1:SEL_W] == '0);

  // R6
  free_run_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_data[SEL_W-1:0] == '0 && $past(cfg_rd_data[SEL_W-1:0]) != '0)
    |=> !start_pulse);
endmodule

bind adc_trig_sel adc_trig_sel_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_rd_data(cfg_rd_data), .auto_en(auto_en),
  .adc_en(adc_en), .conv_busy(conv_busy), .start_pulse(start_pulse)
);

// File: tb/adc_trig_sel_tb_top.sv
module adc_trig_sel_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr_en = 1'b0;
  logic [7:0] cfg_wr_data = '0;
  logic [7:0] cfg_rd_data;
  logic       auto_en = 1'b0;
  logic       adc_en = 1'b0;
  logic [6:0] evt_flags = '0;
  logic       conv_done = 1'b0;
  logic       conv_busy = 1'b0;
  logic       start_pulse;

  int vectors = 0;
  int fails = 0;
  int pulses = 0;
  int cycles = 0;
  string phase = "R11 reset";

  // behavioural reference state
  int m_sel = 0;
  int m_prev_sel = 0;
  int m_prev_sig = 0;
  int exp_start = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_trig_sel dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .auto_en(auto_en), .adc_en(adc_en),
    .evt_flags(evt_flags), .conv_done(conv_done), .conv_busy(conv_busy),
    .start_pulse(start_pulse)
  );

  // Reference model: advance on each rising edge from the values held there.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_sel = 0; m_prev_sel = 0; m_prev_sig = 0; exp_start = 0;
    end else begin
      int sig;
      sig = (m_sel == 0) ? int'(conv_done) : int'(evt_flags[m_sel-1]);
      exp_start = (auto_en && adc_en && !conv_busy && sig == 1 && m_prev_sig == 0
                   && !(m_sel == 0 && m_prev_sel != 0)) ? 1 : 0;
      m_prev_sig = sig;
      m_prev_sel = m_sel;
      if (cfg_wr_en) m_sel = int'(cfg_wr_data[2:0]);
    end
  end

  // Compare on every falling edge.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      vectors++;
      if (int'(start_pulse) != exp_start) begin
        fails++;
        $display("FAIL %s: start_pulse=%0d expected %0d", phase, start_pulse, exp_start);
      end
      vectors++;
      if (cfg_rd_data != 8'(m_sel)) begin
        fails++;
        $display("FAIL %s R7: cfg_rd_data=%02h expected %02h", phase, cfg_rd_data, 8'(m_sel));
      end
      if (start_pulse) pulses++;
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_sel(logic [7:0] v);
    cfg_wr_en = 1'b1; cfg_wr_data = v;
    step(1);
    cfg_wr_en = 1'b0; cfg_wr_data = '0;
  endtask

  task automatic expect_count(int got, int exp, string tag);
    vectors++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: pulse count=%0d expected %0d", tag, got, exp);
    end
  endtask

  initial begin
    int base;
    step(3);
    rst_n = 1'b1;
    step(1);
    expect_count(int'(cfg_rd_data), 0, "R11 reset code");
    expect_count(int'(start_pulse), 0, "R11 reset start");

    phase = "R7"; // reserved and upper bits dropped
    write_sel(8'hFF); step(2);
    expect_count(int'(cfg_rd_data), 7, "R7 readback");
    write_sel(8'h80); step(2);
    expect_count(int'(cfg_rd_data), 0, "R7 reserved ignored");

    auto_en = 1'b1; adc_en = 1'b1;
    phase = "R1";
    for (int s = 1; s < 8; s++) begin
      write_sel(8'(s)); step(2);
      base = pulses;
      evt_flags = 7'h7F & ~(7'(1) << (s-1)); step(3); // others move: ignored
      evt_flags = '0; step(2);
      evt_flags[s-1] = 1'b1; step(4);                  // R3 level held
      evt_flags = '0; step(2);
      expect_count(pulses - base, 1, "R1/R3 one pulse per selected rise");
    end

    phase = "R11"; // fast toggling
    write_sel(8'h02); step(2);
    base = pulses;
    for (int k = 0; k < 4; k++) begin evt_flags[1] = 1'b1; step(1); evt_flags[1] = 1'b0; step(1); end
    step(2);
    expect_count(pulses - base, 4, "R11 toggles");

    phase = "R2";
    auto_en = 1'b0; base = pulses;
    evt_flags[1] = 1'b1; step(3); evt_flags[1] = 1'b0; step(2);
    write_sel(8'h05); evt_flags[4] = 1'b1; step(2); write_sel(8'h02); step(2);
    evt_flags = '0; step(2);
    expect_count(pulses - base, 0, "R2 auto off");

    phase = "R8";
    evt_flags[1] = 1'b1; step(3);
    auto_en = 1'b1; base = pulses; step(4);
    expect_count(pulses - base, 0, "R8 no edge on enable");
    evt_flags = '0; step(2);

    phase = "R5";
    adc_en = 1'b0; base = pulses;
    evt_flags[1] = 1'b1; step(3); evt_flags = '0; step(2);
    expect_count(pulses - base, 0, "R5 adc off");
    adc_en = 1'b1;

    phase = "R4";
    write_sel(8'h01); evt_flags[1] = 1'b1; step(3);
    base = pulses;
    write_sel(8'h02); step(3);
    expect_count(pulses - base, 1, "R4 switch low->high");
    evt_flags = '0; step(2);

    phase = "R6";
    write_sel(8'h03); conv_done = 1'b1; step(3);
    base = pulses;
    write_sel(8'h00); step(4);
    expect_count(pulses - base, 0, "R6 free-run entry");
    conv_done = 1'b0; step(2);

    phase = "R9";
    base = pulses;
    for (int k = 0; k < 3; k++) begin conv_done = 1'b1; step(2); conv_done = 1'b0; step(3); end
    expect_count(pulses - base, 3, "R9 free-run chain");

    phase = "R10";
    conv_busy = 1'b1; base = pulses;
    conv_done = 1'b1; step(3);
    conv_busy = 1'b0; step(4);
    expect_count(pulses - base, 0, "R10 busy drop");
    conv_done = 1'b0; step(2);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    while (cycles < WATCHDOG && !finished) begin @(posedge clk); cycles++; end
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: cycles=%0d expected < %0d", cycles, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule